// File: doc/BRIEF.md
# Digital I/O Register File

This block is a byte-wide register file of sixteen locations that sits behind a simple synchronous read/write bus. Three byte latches drive 24 high-side output lines. A fourth latch drives an 8-bit TTL port whose pads can be switched between driving and receiving. Twenty-four isolated input lines and the TTL pads are sampled through a synchroniser, so software can read the field state. One offset has a read meaning and a different write meaning. Reading it returns the level of the interrupt pin. Writing it resets the board by software.

A bus master makes one access per cycle with `rd_en` or `wr_en`. A write takes effect at the clock edge where it is presented. Read data comes back on the next cycle, qualified by `rvalid`. Bit 1 of the control byte selects the TTL direction. That bit drives the pad output enable directly, so clearing it tri-states the pads. Change-of-state detection is done by a separate block. The offsets it owns read as zero here and ignore writes.

Top module: `dio_regfile`

## Requirements
- R1: While `rst_n` is low, `fet_out`, `ttl_out`, `ttl_oe`, `soft_rst_o`, `rvalid` and `rdata` are all zero.
- R2: A write to offset 0, 1 or 2 loads `fet_out[7:0]`, `[15:8]` or `[23:16]` respectively at that edge. A read of the same offset returns the latched byte.
- R3: A write to offset 3 loads `ttl_out` at that edge, and a read of offset 3 returns that latch whatever the direction.
- R4: A read of offset 4, 5 or 6 returns `iso_in[7:0]`, `[15:8]` or `[23:16]` as sampled through a two-flop synchroniser. The byte returned is the input value present at the clock edge two edges before the read edge.
- R5: Offset 12 is a read/write control byte. `ttl_oe` equals bit 1 of it, where 1 means drive and 0 means tri-state.
- R6: A read of offset 7 returns the `ttl_in` pad value through the same two-flop synchroniser, whether the port drives or receives.
- R7: Writes to offsets 4 to 11, 13 and 14 change no output and no value read back.
- R8: A write to offset 15 clears the three output bytes, the TTL latch and the control byte at that edge. `soft_rst_o` is then high for the following cycle only, unless offset 15 is written again.
- R9: A read of offset 15 returns the synchronised `irq_pin` in bit 0 with bits 7:1 zero. Reads of offsets 8 to 11, 13 and 14 return zero.
- R10: `rvalid` is high exactly in the cycle after a cycle with `rd_en` high. `rdata` holds the read value then and is zero whenever `rvalid` is low.
- R11: When a read and a write to the same offset are presented in the same cycle, the read returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 4 | Byte offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| rvalid | output | 1 | Read data valid |
| fet_out | output | 24 | High-side output latches |
| ttl_out | output | 8 | TTL output latch to the pads |
| ttl_oe | output | 1 | TTL pad output enable |
| ttl_in | input | 8 | TTL pad levels |
| iso_in | input | 24 | Isolated input lines |
| irq_pin | input | 1 | Interrupt output pin level |
| soft_rst_o | output | 1 | Software board reset pulse |

## Verification
Every output latch appears on a port without delay. A wrong output byte, a wrong TTL latch or a wrong control bit therefore shows on `fet_out`, `ttl_out` or `ttl_oe` at the edge after the faulty write. It stays visible until the next write to that offset or a board reset. A wrong synchroniser depth or a wrong read select cannot be seen on the latches. It shows only in `rdata`, one cycle after a read. The bench therefore changes inputs right before reads and reads every offset, including reads that collide with writes.

// File: rtl/dio_pkg.sv
package dio_pkg;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam int N_FET = 3;
  localparam int N_ISO = 3;

  localparam logic [AW-1:0] OFF_FET0    = 4'd0;
  localparam logic [AW-1:0] OFF_TTL_LAT = 4'd3;
  localparam logic [AW-1:0] OFF_ISO0    = 4'd4;
  localparam logic [AW-1:0] OFF_TTL_PAD = 4'd7;
  localparam logic [AW-1:0] OFF_CTRL    = 4'd12;
  localparam logic [AW-1:0] OFF_BRST    = 4'd15;

  localparam int TTL_DIR_BIT = 1;

  // offset of bank b in a group that starts at base
  function automatic logic [AW-1:0] bank_off(logic [AW-1:0] base, int b);
    return base + AW'(b);
  endfunction

  // true for offsets where a write has no effect on any state
  function automatic logic is_write_ignored(logic [AW-1:0] a);
    return !(a <= OFF_TTL_LAT || a == OFF_CTRL || a == OFF_BRST);
  endfunction
endpackage

// File: rtl/dio_sync.sv
module dio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st[s] <= '0;
      else if (s == 0) st[s] <= d;
      else st[s] <= st[(s == 0) ? 0 : s-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/dio_latch.sv
module dio_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else if (we)  q <= wdata;
  end
endmodule

// File: rtl/dio_rd_mux.sv
module dio_rd_mux
  import dio_pkg::*;
(
  input  logic [AW-1:0]            addr,
  input  logic [N_FET-1:0][DW-1:0] fet_q,
  input  logic [DW-1:0]            ttl_q,
  input  logic [N_ISO-1:0][DW-1:0] iso_s,
  input  logic [DW-1:0]            pad_s,
  input  logic [DW-1:0]            ctrl_q,
  input  logic                     irq_s,
  output logic [DW-1:0]            data
);
  always_comb begin
    data = '0;
    for (int b = 0; b < N_FET; b++)
      if (addr == bank_off(OFF_FET0, b)) data = fet_q[b];
    for (int b = 0; b < N_ISO; b++)
      if (addr == bank_off(OFF_ISO0, b)) data = iso_s[b];
    if (addr == OFF_TTL_LAT) data = ttl_q;
    if (addr == OFF_TTL_PAD) data = pad_s;
    if (addr == OFF_CTRL)    data = ctrl_q;
    if (addr == OFF_BRST)    data = {{(DW-1){1'b0}}, irq_s};
  end
endmodule

// File: rtl/dio_regfile.sv
module dio_regfile
  import dio_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_en,
  input  logic                wr_en,
  input  logic [AW-1:0]       addr,
  input  logic [DW-1:0]       wdata,
  output logic [DW-1:0]       rdata,
  output logic                rvalid,
  output logic [N_FET*DW-1:0] fet_out,
  output logic [DW-1:0]       ttl_out,
  output logic                ttl_oe,
  input  logic [DW-1:0]       ttl_in,
  input  logic [N_ISO*DW-1:0] iso_in,
  input  logic                irq_pin,
  output logic                soft_rst_o
);
  // named events for the checker
  logic brst_hit;
  logic wr_ignored;
  logic ctrl_we;
  logic ttl_we;

  assign brst_hit   = wr_en && (addr == OFF_BRST);
  assign wr_ignored = wr_en && is_write_ignored(addr);
  assign ctrl_we    = wr_en && (addr == OFF_CTRL);
  assign ttl_we     = wr_en && (addr == OFF_TTL_LAT);

  logic [N_FET-1:0][DW-1:0] fet_q;
  logic [DW-1:0]            ttl_q;
  logic [DW-1:0]            ctrl_q;

  for (genvar b = 0; b < N_FET; b++) begin : g_fet
    dio_latch #(.W(DW)) u_lat (
      .clk(clk), .rst_n(rst_n), .clr(brst_hit),
      .we(wr_en && (addr == bank_off(OFF_FET0, b))),
      .wdata(wdata), .q(fet_q[b])
    );
  end

  dio_latch #(.W(DW)) u_ttl (
    .clk(clk), .rst_n(rst_n), .clr(brst_hit), .we(ttl_we),
    .wdata(wdata), .q(ttl_q)
  );

  dio_latch #(.W(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .clr(brst_hit), .we(ctrl_we),
    .wdata(wdata), .q(ctrl_q)
  );

  logic [N_ISO*DW-1:0] iso_sync;
  logic [DW-1:0]       pad_sync;
  logic                irq_sync;

  dio_sync #(.W(N_ISO*DW + DW + 1), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({iso_in, ttl_in, irq_pin}),
    .q({iso_sync, pad_sync, irq_sync})
  );

  logic [DW-1:0] rd_next;

  dio_rd_mux u_mux (
    .addr(addr), .fet_q(fet_q), .ttl_q(ttl_q),
    .iso_s(iso_sync), .pad_s(pad_sync), .ctrl_q(ctrl_q),
    .irq_s(irq_sync), .data(rd_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata      <= '0;
      rvalid     <= 1'b0;
      soft_rst_o <= 1'b0;
    end else begin
      rvalid     <= rd_en;
      rdata      <= rd_en ? rd_next : '0;
      soft_rst_o <= brst_hit;
    end
  end

  assign fet_out = fet_q;
  assign ttl_out = ttl_q;
  assign ttl_oe  = ctrl_q[TTL_DIR_BIT];
endmodule

// File: rtl/dio_regfile_chk.sv
module dio_regfile_chk
  import dio_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                rd_en,
  input logic                wr_en,
  input logic [AW-1:0]       addr,
  input logic [DW-1:0]       wdata,
  input logic [DW-1:0]       rdata,
  input logic                rvalid,
  input logic [N_FET*DW-1:0] fet_out,
  input logic [DW-1:0]       ttl_out,
  input logic                ttl_oe,
  input logic                soft_rst_o,
  input logic                brst_hit,
  input logic                wr_ignored,
  input logic                ctrl_we
);
  assert_rvalid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rvalid);
  assert_rvalid_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rvalid);
  assert_rdata_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid |-> rdata == '0);
  assert_fet_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFF_FET0) |=> fet_out[DW-1:0] == $past(wdata));
  assert_oe_ctrl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> ttl_oe == $past(wdata[TTL_DIR_BIT]));
  assert_ignored_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ignored && !brst_hit) |=> ($stable(fet_out) && $stable(ttl_out) && $stable(ttl_oe)));
  assert_brst_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    brst_hit |=> (fet_out == '0 && ttl_out == '0 && !ttl_oe && soft_rst_o));
  assert_brst_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_o |-> $past(wr_en && addr == OFF_BRST));
  assert_irq_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == OFF_BRST) |=> rdata[DW-1:1] == '0);
endmodule

bind dio_regfile dio_regfile_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .fet_out(fet_out),
  .ttl_out(ttl_out), .ttl_oe(ttl_oe), .soft_rst_o(soft_rst_o),
  .brst_hit(brst_hit), .wr_ignored(wr_ignored), .ctrl_we(ctrl_we)
);

// File: tb/sim_dio_regfile.sv
`timescale 1ns/1ps
module sim_dio_regfile;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        rd_en = 0, wr_en = 0;
  logic [3:0]  addr = 0;
  logic [7:0]  wdata = 0;
  logic [7:0]  rdata;
  logic        rvalid;
  logic [23:0] fet_out;
  logic [7:0]  ttl_out;
  logic        ttl_oe;
  logic [7:0]  ttl_in;
  logic [7:0]  ext_ttl = 0;
  logic [23:0] iso_in = 0;
  logic        irq_pin = 0;
  logic        soft_rst_o;

  int tests = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  // pad model: driven pads show the latch, otherwise the field level
  assign ttl_in = ttl_oe ? ttl_out : ext_ttl;

  dio_regfile u0 (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .fet_out(fet_out),
    .ttl_out(ttl_out), .ttl_oe(ttl_oe), .ttl_in(ttl_in), .iso_in(iso_in),
    .irq_pin(irq_pin), .soft_rst_o(soft_rst_o)
  );

  // ---------------- reference model ----------------
  byte unsigned m_lat [4];
  byte unsigned m_ctrl;
  bit           m_srst, m_rv;
  byte unsigned m_rd;
  int           m_rd_addr;
  int unsigned  hist_iso [$];
  int unsigned  hist_pad [$];
  int unsigned  hist_irq [$];

  initial begin
    for (int i = 0; i < 4; i++) m_lat[i] = 0;
    m_ctrl = 0; m_srst = 0; m_rv = 0; m_rd = 0; m_rd_addr = 0;
    hist_iso = '{0, 0}; hist_pad = '{0, 0}; hist_irq = '{0, 0};
  end

  always @(posedge clk) if (rst_n) begin
    int unsigned iso_seen, pad_seen, irq_seen;
    iso_seen = hist_iso.pop_front();
    pad_seen = hist_pad.pop_front();
    irq_seen = hist_irq.pop_front();
    hist_iso.push_back(iso_in);
    hist_pad.push_back(ttl_in);
    hist_irq.push_back(irq_pin);
    m_rv = rd_en;
    m_rd = 0;
    m_rd_addr = addr;
    if (rd_en) begin
      if (addr <= 3)                  m_rd = m_lat[addr];
      else if (addr <= 6)             m_rd = 8'((iso_seen >> (8 * (addr - 4))) & 8'hFF);
      else if (addr == 7)             m_rd = 8'(pad_seen);
      else if (addr == 12)            m_rd = m_ctrl;
      else if (addr == 15)            m_rd = 8'(irq_seen);
    end
    m_srst = 0;
    if (wr_en) begin
      if (addr <= 3)       m_lat[addr] = wdata;
      else if (addr == 12) m_ctrl = wdata;
      else if (addr == 15) begin
        for (int i = 0; i < 4; i++) m_lat[i] = 0;
        m_ctrl = 0;
        m_srst = 1;
      end
    end
  end

  task automatic chk(string tag, int unsigned act, int unsigned exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string rd_tag(int a);
    if (a <= 2) return "R2";
    if (a == 3) return "R3";
    if (a <= 6) return "R4";
    if (a == 7) return "R6";
    if (a == 12) return "R5";
    return "R9";
  endfunction

  // per-clock comparison against the model
  always @(negedge clk) if (rst_n && !done) begin
    chk("R2 fet_out", fet_out, {m_lat[2], m_lat[1], m_lat[0]});
    chk("R3 ttl_out", ttl_out, m_lat[3]);
    chk("R5 ttl_oe", ttl_oe, m_ctrl[1]);
    chk("R8 soft_rst_o", soft_rst_o, m_srst);
    chk("R10 rvalid", rvalid, m_rv);
    if (m_rv) chk({rd_tag(m_rd_addr), " rdata"}, rdata, m_rd);
    else      chk("R10 rdata idle", rdata, 0);
  end

  task automatic bus(bit rd, bit wr, int a, int wd);
    @(negedge clk);
    rd_en = rd; wr_en = wr; addr = 4'(a); wdata = 8'(wd);
    @(negedge clk);
    rd_en = 0; wr_en = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 fet_out", fet_out, 0);
    chk("R1 ttl_out", ttl_out, 0);
    chk("R1 ttl_oe", ttl_oe, 0);
    chk("R1 soft_rst_o", soft_rst_o, 0);
    chk("R1 rvalid", rvalid, 0);
    chk("R1 rdata", rdata, 0);
    rst_n = 1;
    idle(2);

    // R2 / R3 writes and readback
    bus(0, 1, 0, 'hA5); bus(0, 1, 1, 'h3C); bus(0, 1, 2, 'hF0);
    bus(0, 1, 3, 'h5A);
    chk("R2 fet_out direct", fet_out, 24'hF03CA5);
    bus(1, 0, 1, 0);
    chk("R2 read offset 1", rdata, 'h3C);
    bus(1, 0, 3, 0);
    chk("R3 read offset 3", rdata, 'h5A);

    // R6 input mode then R5 output mode
    ext_ttl = 'hC3; idle(3);
    bus(1, 0, 7, 0);
    chk("R6 pads in input mode", rdata, 'hC3);
    bus(0, 1, 12, 'h02);
    chk("R5 oe after ctrl write", ttl_oe, 1);
    idle(3);
    bus(1, 0, 7, 0);
    chk("R6 pads in output mode", rdata, 'h5A);
    bus(1, 0, 12, 0);
    chk("R5 ctrl readback", rdata, 'h02);

    // R4 isolated inputs, settled and just changed
    iso_in = 24'h123456; idle(3);
    bus(1, 0, 4, 0); chk("R4 iso bank0", rdata, 'h56);
    bus(1, 0, 6, 0); chk("R4 iso bank2", rdata, 'h12);
    @(negedge clk); iso_in = 24'hABCDEF; rd_en = 1; addr = 4'd5;
    @(negedge clk); rd_en = 0;
    chk("R4 not yet through synchroniser", rdata, 'h34);
    idle(2);
    bus(1, 0, 5, 0); chk("R4 iso bank1 new", rdata, 'hCD);

    // R7 ignored writes
    for (int a = 4; a <= 14; a++)
      if (a <= 11 || a == 13 || a == 14) bus(0, 1, a, 'hFF);
    chk("R7 fet unchanged", fet_out, 24'hF03CA5);
    chk("R7 ttl unchanged", ttl_out, 'h5A);
    chk("R7 oe unchanged", ttl_oe, 1);
    bus(1, 0, 13, 0); chk("R9 reserved reads zero", rdata, 0);

    // R11 read and write in the same cycle
    bus(1, 1, 1, 'h77);
    chk("R11 read returns old value", rdata, 'h3C);
    chk("R11 write still lands", fet_out[15:8], 'h77);

    // R9 interrupt pin readback
    irq_pin = 1; idle(3);
    bus(1, 0, 15, 0); chk("R9 irq pin high", rdata, 1);
    irq_pin = 0; idle(3);
    bus(1, 0, 15, 0); chk("R9 irq pin low", rdata, 0);

    // R8 board reset
    @(negedge clk); wr_en = 1; addr = 4'd15; wdata = 'h00;
    @(negedge clk); wr_en = 0;
    chk("R8 fet cleared", fet_out, 0);
    chk("R8 ttl cleared", ttl_out, 0);
    chk("R8 oe cleared", ttl_oe, 0);
    chk("R8 pulse high", soft_rst_o, 1);
    @(negedge clk);
    chk("R8 pulse one cycle", soft_rst_o, 0);

    // mixed traffic checked by the model every clock
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      rd_en = 1'($urandom_range(0, 1));
      wr_en = 1'($urandom_range(0, 3) == 0);
      addr = 4'($urandom_range(0, 15));
      if (wr_en && addr == 15 && $urandom_range(0, 7) != 0) addr = 4'd12;
      wdata = 8'($urandom);
      if ($urandom_range(0, 3) == 0) iso_in = 24'($urandom);
      if ($urandom_range(0, 3) == 0) ext_ttl = 8'($urandom);
      if ($urandom_range(0, 7) == 0) irq_pin = ~irq_pin;
    end
    @(negedge clk); rd_en = 0; wr_en = 0;
    idle(3);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule